// File: doc/BRIEF.md
# Program-Mode Entry Sequencer and Word Address Counter

This block is the target-side sequencer used while a one-time-programmable code memory is written over a serial link. It watches a digital flag that reports a high programming voltage on the reset pin. It also watches two data-pin levels. Program/verify mode is armed only when both data pins are low in the cycle in which the flag goes from low to high. The mode stays armed for as long as the flag is high. The mode is left, and all state is cleared, as soon as the flag drops.

Inside the mode, a word counter selects one memory location. After entry it points at the configuration word, which sits logically ahead of user address zero. Each increment-address command moves it forward one location. The first command reaches user word 0x000. Later commands walk the user area up to its last word. One more command crosses into a separate special area, which is addressed right after the user words. The counter stops at the final special word and does not wrap. The host-side shift protocol, the voltage sensing and the memory array are not part of this block.

Top module: `pgm_seq_top`

## Requirements
- R1: While rst_ni is low, mode_o is 0, region_o is 2'b00 (configuration) and addr_o is 0.
- R2: mode_o goes to 1 one clock after a cycle in which hv_i is 1, hv_i was 0 in the previous cycle, and pin_a_i and pin_b_i are both 0. If either pin is 1 in that cycle, the mode stays off until hv_i falls and rises again. Pin changes while the mode is armed have no effect.
- R3: Right after entry, region_o is 2'b00 (configuration) and addr_o is 0.
- R4: The first increment (inc_i high for one cycle while mode_o is 1) gives region_o 2'b01 (user) and addr_o 0x000 on the next clock.
- R5: Each further increment inside the user area raises addr_o by one, up to USER_WORDS-1 (0x3FF by default).
- R6: An increment at the last user word gives region_o 2'b10 (special) and addr_o = USER_WORDS (0x400 by default).
- R7: Increments at the last special word (USER_WORDS+SPCL_WORDS-1, 0x40F by default) leave addr_o and region_o unchanged.
- R8: One clock after a cycle with hv_i at 0, mode_o is 0, region_o is configuration and addr_o is 0.
- R9: inc_i has no effect while mode_o is 0. region_o stays configuration and addr_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hv_i | input | 1 | High programming voltage present on the reset pin |
| pin_a_i | input | 1 | First sampled data-pin level |
| pin_b_i | input | 1 | Second sampled data-pin level |
| inc_i | input | 1 | Increment-address command, one cycle per step |
| mode_o | output | 1 | Program/verify mode armed |
| region_o | output | 2 | 00 configuration, 01 user, 10 special |
| addr_o | output | ADDR_W | Selected word address (0 while on configuration) |

## Verification
If the counter drifted, region_o and addr_o would show it one clock after the faulty increment, because both are read straight from the counter register. Every step of a full walk from the configuration word to the saturated end of the special area is compared. So an off-by-one at the user/special boundary, or a wrap instead of a stop, shows up in that same cycle. A wrong entry or exit state shows up in mode_o and region_o one clock after the hv_i edge. Increments are issued while the mode is off, so a counter that steps when it should not is also seen at once.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'b00,
    REG_USER = 2'b01,
    REG_SPCL = 2'b10
  } region_e;
endpackage

// File: rtl/pgm_entry_det.sv
module pgm_entry_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hv_i,
  input  logic pin_a_i,
  input  logic pin_b_i,
  output logic mode_o
);
  logic hv_q;
  logic mode_q;
  logic hv_rise;

  assign hv_rise = hv_i && !hv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      hv_q <= hv_i;
      if (!hv_i)                              mode_q <= 1'b0;
      else if (hv_rise && !pin_a_i && !pin_b_i) mode_q <= 1'b1;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr #(
  parameter int unsigned LAST  = 1040,
  parameter int unsigned IDX_W = $clog2(LAST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(LAST);

  logic [IDX_W-1:0] idx_q;

  // index 0 is the configuration word; saturates at LAST
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        idx_q <= '0;
    else if (clr_i)                     idx_q <= '0;
    else if (step_i && idx_q != LastIdx) idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/pgm_region_dec.sv
module pgm_region_dec
  import pgm_seq_pkg::*;
#(
  parameter int unsigned USER_WORDS = 1024,
  parameter int unsigned IDX_W      = 11,
  parameter int unsigned ADDR_W     = 11
) (
  input  logic [IDX_W-1:0]  idx_i,
  output region_e           region_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [IDX_W-1:0] UserTop = IDX_W'(USER_WORDS);

  logic [IDX_W-1:0] lin;
  assign lin = idx_i - 1'b1;

  always_comb begin
    if (idx_i == '0) begin
      region_o = REG_CFG;
      addr_o   = '0;
    end else begin
      region_o = (idx_i <= UserTop) ? REG_USER : REG_SPCL;
      addr_o   = ADDR_W'(lin);
    end
  end
endmodule

// File: rtl/pgm_seq_top.sv
module pgm_seq_top
  import pgm_seq_pkg::*;
#(
  parameter int unsigned USER_WORDS = 1024,
  parameter int unsigned SPCL_WORDS = 16,
  localparam int unsigned TOTAL     = USER_WORDS + SPCL_WORDS,
  localparam int unsigned ADDR_W    = $clog2(TOTAL),
  localparam int unsigned IDX_W     = $clog2(TOTAL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hv_i,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  input  logic              inc_i,
  output logic              mode_o,
  output logic [1:0]        region_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic             mode;
  logic [IDX_W-1:0] idx;
  region_e          region;

  pgm_entry_det u_entry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hv_i    (hv_i),
    .pin_a_i (pin_a_i),
    .pin_b_i (pin_b_i),
    .mode_o  (mode)
  );

  pgm_addr_ctr #(.LAST(TOTAL), .IDX_W(IDX_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!hv_i),
    .step_i (mode && inc_i),
    .idx_o  (idx)
  );

  pgm_region_dec #(.USER_WORDS(USER_WORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .idx_i    (idx),
    .region_o (region),
    .addr_o   (addr_o)
  );

  assign mode_o   = mode;
  assign region_o = region;
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
  parameter int unsigned USER_WORDS = 1024,
  parameter int unsigned SPCL_WORDS = 16,
  parameter int unsigned ADDR_W     = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hv_i,
  input logic              pin_a_i,
  input logic              pin_b_i,
  input logic              inc_i,
  input logic              mode_o,
  input logic [1:0]        region_o,
  input logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] UserLast = ADDR_W'(USER_WORDS - 1);
  localparam logic [ADDR_W-1:0] SpclLast = ADDR_W'(USER_WORDS + SPCL_WORDS - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk_i) !rst_ni |-> (!mode_o && region_o == 2'b00 && addr_o == '0));

  // R2
  no_entry_pins_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && (pin_a_i || pin_b_i)) |=> !mode_o);

  // R4
  cfg_to_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && hv_i && inc_i && region_o == 2'b00) |=> (region_o == 2'b01 && addr_o == '0));

  // R5
  user_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && hv_i && inc_i && region_o == 2'b01 && addr_o != UserLast)
    |=> (region_o == 2'b01 && addr_o == $past(addr_o) + 1'b1));

  // R6
  user_to_spcl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && hv_i && inc_i && region_o == 2'b01 && addr_o == UserLast)
    |=> (region_o == 2'b10 && addr_o == ADDR_W'(USER_WORDS)));

  // R7
  spcl_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && hv_i && region_o == 2'b10 && addr_o == SpclLast) |=> ($stable(addr_o) && region_o == 2'b10));

  // R8
  exit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv_i |=> (!mode_o && region_o == 2'b00 && addr_o == '0));

  // R9
  idle_inc_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |=> (region_o == 2'b00 && addr_o == '0));
endmodule

bind pgm_seq_top pgm_seq_chk #(
  .USER_WORDS(USER_WORDS), .SPCL_WORDS(SPCL_WORDS), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/pgm_seq_top_tb.sv
module pgm_seq_top_tb;
  localparam int USER_WORDS = 1024;
  localparam int SPCL_WORDS = 16;
  localparam int ADDR_W     = $clog2(USER_WORDS + SPCL_WORDS);

  typedef struct {
    logic              mode;
    logic [1:0]        region;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } exp_t;

  logic clk = 0, rst_n = 0, hv = 0, pa = 0, pb = 0, inc = 0;
  logic              mode_o;
  logic [1:0]        region_o;
  logic [ADDR_W-1:0] addr_o;

  int n_chk = 0, n_fail = 0;
  exp_t q[$];

  // bench model state
  bit m_mode = 0, m_hv_prev = 0;
  int m_idx = 0;

  always #10 clk = ~clk;

  pgm_seq_top #(.USER_WORDS(USER_WORDS), .SPCL_WORDS(SPCL_WORDS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hv_i(hv), .pin_a_i(pa), .pin_b_i(pb),
    .inc_i(inc), .mode_o(mode_o), .region_o(region_o), .addr_o(addr_o)
  );

  task automatic check(string tag, logic m, logic [1:0] r, logic [ADDR_W-1:0] a);
    n_chk++;
    if (mode_o !== m || region_o !== r || addr_o !== a) begin
      n_fail++;
      $display("FAIL %s: got mode=%0b region=%0b addr=%0h exp mode=%0b region=%0b addr=%0h",
               tag, mode_o, region_o, addr_o, m, r, a);
    end
  endtask

  task automatic step(bit h, bit a, bit b, bit i, string tag);
    exp_t e;
    bit old_mode;
    @(negedge clk);
    hv = h; pa = a; pb = b; inc = i;
    old_mode = m_mode;
    if (!h) begin
      m_mode = 0; m_idx = 0;
    end else begin
      if (old_mode && i && m_idx < USER_WORDS + SPCL_WORDS) m_idx++;
      if (!m_hv_prev && !a && !b) m_mode = 1;
    end
    m_hv_prev = h;
    e.mode = m_mode;
    if (m_idx == 0) begin e.region = 2'b00; e.addr = '0; end
    else begin
      e.region = (m_idx <= USER_WORDS) ? 2'b01 : 2'b10;
      e.addr   = ADDR_W'(m_idx - 1);
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: sample 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, e.mode, e.region, e.addr);
    end
  end

  initial begin
    #10000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 2'b00, '0);
    rst_n = 1;
    step(0, 0, 0, 0, "R8 idle");
    // rise with pin_a high: no entry
    step(1, 1, 0, 0, "R2 pin_a high at rise");
    step(1, 0, 0, 0, "R2 pins low later");
    step(1, 0, 0, 1, "R9 inc while not in mode");
    step(1, 0, 0, 1, "R9 inc while not in mode again");
    step(0, 0, 0, 0, "R8 drop");
    // rise with pin_b high
    step(1, 0, 1, 0, "R2 pin_b high at rise");
    step(1, 0, 0, 1, "R9 inc ignored pin_b case");
    step(0, 0, 0, 1, "R9 inc with hv low");
    // valid entry
    step(1, 0, 0, 0, "R3 entry config");
    step(1, 1, 1, 0, "R2 pins toggled in mode");
    step(1, 0, 0, 1, "R4 first inc user 0");
    for (int k = 1; k < USER_WORDS; k++) step(1, k[0], 0, 1, "R5 user walk");
    step(1, 0, 0, 0, "R5 hold at last user");
    step(1, 0, 0, 1, "R6 into special");
    for (int k = 1; k < SPCL_WORDS; k++) step(1, 0, 0, 1, "R6 special walk");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 1, "R7 saturate");
    step(0, 0, 0, 0, "R8 exit clears");
    step(0, 0, 0, 1, "R9 inc after exit");
    // re-entry restarts at config
    step(1, 0, 0, 0, "R3 re-entry config");
    step(1, 0, 0, 1, "R4 re-entry first inc");
    step(1, 0, 0, 1, "R5 re-entry second inc");
    step(0, 0, 0, 0, "R8 final exit");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule